// File: doc/BRIEF.md
# DMA Transfer Sequencer with Byte-Enable Generation

This block steps a single DMA channel through its transfers toward a peripheral that holds a request line. A start pulse loads the channel number, the transfer mode and the autoinitialize flag. Each transfer is an I/O cycle followed by a memory cycle. The I/O cycle lasts until the peripheral strobes target-ready. The memory cycle then runs for a fixed number of clocks. During the I/O cycle the block drives active-low byte enables that fit the data width of the channel.

At each target-ready strobe the block decides whether the sequence ends after the current transfer. It uses the terminal-count indication from the channel's count register, the autoinitialize flag and the mode. It also uses the request line as it stood a fixed number of clocks before the strobe. A peripheral that drops its request too late therefore receives one more complete transfer.

Top module: `dma_xfer_seq`

## Requirements
- R1: During and directly after reset, `be_n` is all ones and `busy`, `io_cyc`, `mem_cyc`, `tc_pulse` and `seq_done` are low.
- R2: Channels 0, 1, 2 and 3 are 8-bit channels. In a non-verify I/O cycle on one of them, `be_n` equals 4'b1110.
- R3: Channels 5, 6 and 7 are 16-bit channels. In a non-verify I/O cycle on one of them, `be_n` equals 4'b1100.
- R4: Mode encoding on `xfer_mode` is 0 single, 1 demand, 2 verify, 3 increment. In verify mode `be_n` stays 4'b1111 during I/O cycles and no memory cycle is run.
- R5: Channel 4 is reserved. A start request that names it is ignored, and `busy` stays low.
- R6: Whenever `io_cyc` is low, `be_n` is 4'b1111.
- R7: In every mode except verify, the clock edge that samples `tgt_rdy` during an I/O cycle ends that cycle. `mem_cyc` is then high for exactly MEM_CLKS (default 2) clocks.
- R8: In single mode the sequence ends after its first transfer, whatever the request and count inputs are.
- R9: If `tc_hit` is high at the strobe and autoinitialize is clear, the sequence ends after that transfer. With autoinitialize set, `tc_hit` by itself does not end the sequence.
- R10: The request line is qualified at the strobe edge by its value sampled REQ_LAG (default 7) edges earlier. The history of the line reads as deasserted just after reset. If that value is low, the sequence ends after the current transfer. A drop that comes later than that point lets one more full transfer run.
- R11: `tc_pulse` is high for the one clock that follows a strobe edge at which `tc_hit` was high.
- R12: `seq_done` is high for the one clock that follows the end of the final transfer, and `busy` is low in that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence when idle |
| chan_sel | input | 3 | Channel number, sampled with `start` |
| xfer_mode | input | 2 | Transfer mode, sampled with `start` |
| auto_init | input | 1 | Autoinitialize flag, sampled with `start` |
| periph_req | input | 1 | Peripheral request line, active high |
| tgt_rdy | input | 1 | Target-ready strobe that ends the I/O cycle |
| tc_hit | input | 1 | Terminal count reached on this transfer |
| be_n | output | 4 | Active-low byte enables |
| io_cyc | output | 1 | I/O cycle in progress |
| mem_cyc | output | 1 | Memory cycle in progress |
| busy | output | 1 | Sequence active |
| tc_pulse | output | 1 | One-clock terminal-count pulse |
| seq_done | output | 1 | One-clock end-of-sequence pulse |

## Verification
The bench builds the block with its default parameters. These are a 3-bit channel field, four byte lanes, a request lag of 7 and a two-clock memory cycle. With these values both channel groups and the reserved channel 4 can be reached. They also make the request window short enough to put a drop on either side of the lag boundary directly. The bench keeps its own seven-deep record of the request values it drove, and uses it to predict every termination decision across random mixes of mode, autoinitialize, count and request activity.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'd0,
      MODE_DEMAND = 2'd1,
      MODE_VERIFY = 2'd2,
      MODE_INCR   = 2'd3
   } xfer_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_IO   = 2'd1,
      ST_MEM  = 2'd2
   } seq_state_e;

   typedef struct packed {
      xfer_mode_e mode;
      logic       auto_init;
      logic       wide;
   } chan_cfg_t;

endpackage

// File: rtl/dma_width_decode.sv
module dma_width_decode #(
   parameter int CHAN_W    = 3,
   parameter int RSVD_CHAN = 4,
   parameter int WIDE_BASE = RSVD_CHAN + 1
) (
   input  logic [CHAN_W-1:0] chan,
   output logic              chan_ok,
   output logic              wide
);
   localparam int NUM_CHAN = 1 << CHAN_W;

   if (RSVD_CHAN >= NUM_CHAN) begin : g_bad_rsvd
      $error("RSVD_CHAN outside channel range");
   end
   if (WIDE_BASE > NUM_CHAN) begin : g_bad_wide
      $error("WIDE_BASE outside channel range");
   end

   always_comb begin
      chan_ok = (int'(chan) != RSVD_CHAN);
      wide    = (int'(chan) >= WIDE_BASE);
   end
endmodule

// File: rtl/dma_be_gen.sv
module dma_be_gen #(
   parameter int BE_W         = 4,
   parameter int NARROW_LANES = 1,
   parameter int WIDE_LANES   = 2
) (
   input  logic            io_active,
   input  logic            wide,
   input  logic            verify,
   output logic [BE_W-1:0] be_n
);
   localparam int LANE_CW = $clog2(BE_W + 1);

   if (NARROW_LANES < 1 || NARROW_LANES > BE_W) begin : g_bad_narrow
      $error("NARROW_LANES out of range");
   end
   if (WIDE_LANES < NARROW_LANES || WIDE_LANES > BE_W) begin : g_bad_widel
      $error("WIDE_LANES out of range");
   end

   logic [LANE_CW-1:0] lanes;

   always_comb begin
      if (!io_active || verify) lanes = '0;
      else if (wide)            lanes = LANE_CW'(WIDE_LANES);
      else                      lanes = LANE_CW'(NARROW_LANES);
   end

   for (genvar i = 0; i < BE_W; i++) begin : g_lane
      assign be_n[i] = !(LANE_CW'(i) < lanes);
   end
endmodule

// File: rtl/dma_req_hist.sv
module dma_req_hist #(
   parameter int LAG = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_in,
   output logic req_q
);
   if (LAG < 0) begin : g_bad_lag
      $error("LAG must not be negative");
   end

   if (LAG == 0) begin : g_bypass
      assign req_q = req_in;
   end else if (LAG == 1) begin : g_single
      logic hist_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist_q <= 1'b0;
         else        hist_q <= req_in;
      end
      assign req_q = hist_q;
   end else begin : g_shift
      logic [LAG-1:0] hist_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist_q <= '0;
         else        hist_q <= {hist_q[LAG-2:0], req_in};
      end
      assign req_q = hist_q[LAG-1];
   end
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
   import dma_seq_pkg::*;
#(
   parameter int MEM_CLKS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       chan_ok,
   input  logic       wide_in,
   input  xfer_mode_e mode_in,
   input  logic       auto_in,
   input  logic       tgt_rdy,
   input  logic       tc_hit,
   input  logic       req_q,
   output logic       io_cyc,
   output logic       mem_cyc,
   output logic       busy,
   output logic       tc_pulse,
   output logic       seq_done,
   output chan_cfg_t  cfg
);
   localparam int CNT_W = (MEM_CLKS > 1) ? $clog2(MEM_CLKS) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MEM_CLKS - 1);

   if (MEM_CLKS < 1) begin : g_bad_mem
      $error("MEM_CLKS must be at least 1");
   end

   seq_state_e       state_q;
   chan_cfg_t        cfg_q;
   logic [CNT_W-1:0] cnt_q;
   logic             end_q;
   logic             end_now;

   always_comb begin
      end_now = (cfg_q.mode == MODE_SINGLE) ||
                (tc_hit && !cfg_q.auto_init) ||
                !req_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cfg_q    <= '0;
         cnt_q    <= '0;
         end_q    <= 1'b0;
         tc_pulse <= 1'b0;
         seq_done <= 1'b0;
      end else begin
         tc_pulse <= 1'b0;
         seq_done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start && chan_ok) begin
                  cfg_q.mode      <= mode_in;
                  cfg_q.auto_init <= auto_in;
                  cfg_q.wide      <= wide_in;
                  state_q         <= ST_IO;
               end
            end
            ST_IO: begin
               if (tgt_rdy) begin
                  tc_pulse <= tc_hit;
                  if (cfg_q.mode == MODE_VERIFY) begin
                     if (end_now) begin
                        state_q  <= ST_IDLE;
                        seq_done <= 1'b1;
                     end
                  end else begin
                     state_q <= ST_MEM;
                     end_q   <= end_now;
                     cnt_q   <= '0;
                  end
               end
            end
            ST_MEM: begin
               if (cnt_q == CNT_LAST) begin
                  if (end_q) begin
                     state_q  <= ST_IDLE;
                     seq_done <= 1'b1;
                  end else begin
                     state_q <= ST_IO;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign io_cyc  = (state_q == ST_IO);
   assign mem_cyc = (state_q == ST_MEM);
   assign busy    = (state_q != ST_IDLE);
   assign cfg     = cfg_q;

   // R4: verify sequences never enter the memory phase
   p_verify_nomem_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cyc |-> (cfg_q.mode != MODE_VERIFY));

   // R8: single mode leaves for idle at the end of its memory phase
   p_single_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cyc && cnt_q == CNT_LAST && cfg_q.mode == MODE_SINGLE) |=> !busy);

   // R9: terminal count without autoinitialize marks the transfer final
   p_tc_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (io_cyc && tgt_rdy && tc_hit && !cfg_q.auto_init &&
       cfg_q.mode != MODE_VERIFY) |=> (mem_cyc && end_q));
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
   import dma_seq_pkg::*;
#(
   parameter int CHAN_W    = 3,
   parameter int BE_W      = 4,
   parameter int RSVD_CHAN = 4,
   parameter int REQ_LAG   = 7,
   parameter int MEM_CLKS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CHAN_W-1:0] chan_sel,
   input  logic [1:0]        xfer_mode,
   input  logic              auto_init,
   input  logic              periph_req,
   input  logic              tgt_rdy,
   input  logic              tc_hit,
   output logic [BE_W-1:0]   be_n,
   output logic              io_cyc,
   output logic              mem_cyc,
   output logic              busy,
   output logic              tc_pulse,
   output logic              seq_done
);
   localparam logic [BE_W-1:0] BE_IDLE = '1;

   logic      chan_ok, wide;
   logic      req_q;
   chan_cfg_t cfg;

   dma_width_decode #(
      .CHAN_W   (CHAN_W),
      .RSVD_CHAN(RSVD_CHAN)
   ) u_decode (
      .chan   (chan_sel),
      .chan_ok(chan_ok),
      .wide   (wide)
   );

   dma_req_hist #(
      .LAG(REQ_LAG)
   ) u_hist (
      .clk   (clk),
      .rst_n (rst_n),
      .req_in(periph_req),
      .req_q (req_q)
   );

   dma_seq_fsm #(
      .MEM_CLKS(MEM_CLKS)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .chan_ok (chan_ok),
      .wide_in (wide),
      .mode_in (xfer_mode_e'(xfer_mode)),
      .auto_in (auto_init),
      .tgt_rdy (tgt_rdy),
      .tc_hit  (tc_hit),
      .req_q   (req_q),
      .io_cyc  (io_cyc),
      .mem_cyc (mem_cyc),
      .busy    (busy),
      .tc_pulse(tc_pulse),
      .seq_done(seq_done),
      .cfg     (cfg)
   );

   dma_be_gen #(
      .BE_W(BE_W)
   ) u_be (
      .io_active(io_cyc),
      .wide     (cfg.wide),
      .verify   (cfg.mode == MODE_VERIFY),
      .be_n     (be_n)
   );

   // R6: byte enables inactive outside I/O cycles
   p_be_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !io_cyc |-> (be_n == BE_IDLE));

   // R5: a sequence only starts for a non-reserved channel
   p_rsvd_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (int'($past(chan_sel)) != RSVD_CHAN));

   // R7: a memory phase is always entered from an I/O cycle
   p_mem_after_io_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_cyc) |-> $past(io_cyc && tgt_rdy));

   // R11: the count pulse follows a strobe that carried terminal count
   p_tc_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tc_pulse |-> $past(io_cyc && tgt_rdy && tc_hit));

   // R12: end pulse only while idle
   p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> !busy);
endmodule

// File: tb/dma_xfer_seq_tb.sv
module dma_xfer_seq_tb;
   localparam int MEM_CLKS = 2;
   localparam int LAG      = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] chan_sel = '0;
   logic [1:0] xfer_mode = '0;
   logic       auto_init = 1'b0;
   logic       periph_req = 1'b0;
   logic       tgt_rdy = 1'b0;
   logic       tc_hit = 1'b0;
   logic [3:0] be_n;
   logic       io_cyc, mem_cyc, busy, tc_pulse, seq_done;

   int tests = 0;
   int fails = 0;
   logic [LAG-1:0] drv_hist;

   always #10 clk = ~clk;

   dma_xfer_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
      .xfer_mode(xfer_mode), .auto_init(auto_init), .periph_req(periph_req),
      .tgt_rdy(tgt_rdy), .tc_hit(tc_hit), .be_n(be_n), .io_cyc(io_cyc),
      .mem_cyc(mem_cyc), .busy(busy), .tc_pulse(tc_pulse), .seq_done(seq_done)
   );

   // record of the request values driven, per R10
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) drv_hist <= '0;
      else        drv_hist <= {drv_hist[LAG-2:0], periph_req};
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] exp_be(input int ch, input int md);
      if (md == 2) return 4'b1111;
      if (ch >= 5) return 4'b1100;
      return 4'b1110;
   endfunction

   function automatic string be_tag(input int ch, input int md);
      if (md == 2) return "R4";
      if (ch >= 5) return "R3";
      return "R2";
   endfunction

   function automatic bit exp_end(input int md, input bit tc, input bit ai, input bit req7);
      return (md == 0) || (tc && !ai) || !req7;
   endfunction

   function automatic string end_tag(input int md, input bit tc, input bit ai);
      if (md == 0) return "R8";
      if (tc && !ai) return "R9";
      return "R10";
   endfunction

   // req_sel: 0 low, 1 high, 2 random with pct high
   function automatic logic pick_req(input int req_sel, input int pct);
      if (req_sel == 0) return 1'b0;
      if (req_sel == 1) return 1'b1;
      return ($urandom_range(99) < pct);
   endfunction

   task automatic begin_seq(input int ch, input int md, input bit ai);
      @(negedge clk);
      chan_sel = 3'(ch); xfer_mode = 2'(md); auto_init = ai; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic do_xfer(input int ch, input int md, input bit ai, input int waits,
                          input int req_sel, input int pct, input bit tc, output bit en);
      chk("R7 io", io_cyc, 1);
      chk(be_tag(ch, md), be_n, exp_be(ch, md));
      for (int w = 0; w < waits; w++) begin
         periph_req = pick_req(req_sel, pct);
         @(negedge clk);
         chk(be_tag(ch, md), {io_cyc, be_n}, {1'b1, exp_be(ch, md)});
      end
      periph_req = pick_req(req_sel, pct);
      tgt_rdy = 1'b1; tc_hit = tc;
      en = exp_end(md, tc, ai, drv_hist[LAG-1]);
      @(negedge clk);
      tgt_rdy = 1'b0; tc_hit = 1'b0;
      chk("R11", tc_pulse, tc);
      if (md == 2) begin
         chk("R4 nomem", mem_cyc, 0);
         chk(end_tag(md, tc, ai), {seq_done, io_cyc}, {en, !en});
      end else begin
         chk("R7 mem", {mem_cyc, io_cyc}, 2'b10);
         chk("R6", be_n, 4'b1111);
         for (int k = 1; k < MEM_CLKS; k++) begin
            periph_req = pick_req(req_sel, pct);
            @(negedge clk);
            chk("R7 len", mem_cyc, 1);
         end
         periph_req = pick_req(req_sel, pct);
         @(negedge clk);
         chk("R7 end", mem_cyc, 0);
         chk(end_tag(md, tc, ai), {seq_done, io_cyc, busy}, {en, !en, !en});
      end
      if (en) begin
         @(negedge clk);
         chk("R12", seq_done, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual busy expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      bit en;
      void'($urandom(32'h1d5a_0c3e));
      repeat (3) @(negedge clk);
      chk("R1", {be_n, busy, io_cyc, mem_cyc, tc_pulse, seq_done}, {4'hf, 5'b0});
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 post", {be_n, busy, io_cyc, mem_cyc, tc_pulse, seq_done}, {4'hf, 5'b0});

      // R5: reserved channel ignored
      begin_seq(4, 1, 1'b0);
      chk("R5", {busy, io_cyc, be_n}, {2'b00, 4'hf});

      // R8: single mode, request high and no count
      periph_req = 1'b1;
      repeat (LAG + 1) @(negedge clk);
      begin_seq(2, 0, 1'b0);
      do_xfer(2, 0, 1'b0, 2, 1, 0, 1'b0, en);
      chk("R8 single", en, 1);

      // R10: late drop yields one extra transfer, early drop ends
      repeat (LAG + 1) @(negedge clk);
      begin_seq(6, 1, 1'b0);
      do_xfer(6, 1, 1'b0, 4, 1, 0, 1'b0, en);
      do_xfer(6, 1, 1'b0, 3, 0, 0, 1'b0, en);
      chk("R10 late drop", en, 0);
      do_xfer(6, 1, 1'b0, 8, 0, 0, 1'b0, en);
      chk("R10 early drop", en, 1);

      // R9: autoinitialize keeps running past terminal count
      periph_req = 1'b1;
      repeat (LAG + 1) @(negedge clk);
      begin_seq(1, 3, 1'b1);
      do_xfer(1, 3, 1'b1, 1, 1, 0, 1'b1, en);
      chk("R9 autoinit", en, 0);
      do_xfer(1, 3, 1'b1, 8, 0, 0, 1'b0, en);
      begin_seq(7, 1, 1'b0);
      do_xfer(7, 1, 1'b0, 1, 1, 0, 1'b1, en);
      chk("R9 tc end", en, 1);

      // R4: verify on a wide channel
      periph_req = 1'b1;
      repeat (LAG + 1) @(negedge clk);
      begin_seq(5, 2, 1'b0);
      do_xfer(5, 2, 1'b0, 0, 1, 0, 1'b0, en);
      do_xfer(5, 2, 1'b0, 2, 1, 0, 1'b1, en);
      chk("R4 verify end", en, 1);

      // random sequences
      for (int s = 0; s < 60; s++) begin
         int ch, md, n;
         bit ai;
         do ch = $urandom_range(7); while (ch == 4);
         md = $urandom_range(3);
         ai = $urandom_range(1);
         periph_req = 1'b1;
         repeat ($urandom_range(LAG + 2)) @(negedge clk);
         begin_seq(ch, md, ai);
         en = 1'b0;
         n = 0;
         while (!en && n < 40) begin
            do_xfer(ch, md, ai, $urandom_range(9), 2, 85,
                    ($urandom_range(99) < 20), en);
            n++;
         end
         if (!en) do_xfer(ch, md, ai, LAG + 1, 0, 0, 1'b0, en);
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule